// File: doc/BRIEF.md
# Register and I/O Instruction Unit

This unit carries out the execute step of the instructions that touch no memory operand. The sequencer pulses `exec_t3` in the single timing step in which such an instruction is carried out. `mode_i` then selects one of two groups. With `mode_i` low the unit works on the accumulator and the carry bit. With `mode_i` high it works on the byte-wide input and output registers, their ready flags and the interrupt enable. Within a group, exactly one set bit of the 12-bit operation field names the operation. The unit owns the architectural state it changes: the accumulator, the carry bit, the program counter (which it only ever advances by one), the run flag, the interrupt enable, the two ready flags and the byte-wide input and output registers.

A device on the input side writes a byte by pulsing `in_strobe` with the byte on `in_data`. This captures the byte and raises the input flag. A device on the output side pulses `out_ready` once it has taken the previous byte, and this raises the output flag. In every cycle in which an instruction is executed, the unit asks the sequencer to restart its step count.

Top module: `regio_exec_unit`

## Requirements
- R1: After synchronous active-low reset: accumulator 0, carry 0, program counter 0, run flag 1, interrupt enable 0, input flag 0, output flag 0, output register 0.
- R2: `sc_clr_o` is high in exactly the cycles in which `exec_t3` is high, whatever the operation field holds.
- R3: In a cycle without `exec_t3`, the accumulator, carry, program counter, run flag, interrupt enable and output register keep their values.
- R4: Register group (`mode_i`=0) clear and complement operations: bit 11 clears the accumulator, bit 10 clears the carry, bit 9 inverts the accumulator, bit 8 inverts the carry.
- R5: Bit 7 rotates right through the carry: the accumulator's top bit takes the old carry and the carry takes the old bit 0. Bit 6 rotates left: the carry takes the old top bit and bit 0 takes the old carry.
- R6: Bit 5 adds one to the accumulator modulo 2^16 and leaves the carry unchanged.
- R7: Bits 4, 3, 2 and 1 advance the program counter by one when, respectively, the accumulator's top bit is 0, the top bit is 1, the accumulator is zero, or the carry is 0. Otherwise the program counter is unchanged. The program counter wraps modulo 2^12.
- R8: Bit 0 clears the run flag. Only reset sets it again.
- R9: An `in_strobe` pulse stores `in_data` in the input register and sets the input flag. I/O group (`mode_i`=1) bit 11 loads the accumulator's low 8 bits from the input register, keeps the upper 8 bits, and clears the input flag. A strobe in that same cycle leaves the flag set.
- R10: I/O bit 10 copies the accumulator's low 8 bits into the output register and clears the output flag. An `out_ready` pulse sets the output flag, and it wins over a clear in the same cycle.
- R11: I/O bit 9 advances the program counter when the input flag is set. Bit 8 advances it when the output flag is set.
- R12: I/O bit 7 sets the interrupt enable and bit 6 clears it.
- R13: An operation field without exactly one set bit changes no state. For the register group all 12 bits count. For the I/O group only bits 11 to 6 count, and bits 5 to 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_t3 | input | 1 | Execute strobe for this instruction class |
| mode_i | input | 1 | Group select: 0 register, 1 I/O |
| op_bits | input | 12 | One-hot operation field |
| in_data | input | 8 | Byte from the input device |
| in_strobe | input | 1 | Input byte valid pulse |
| out_ready | input | 1 | Output device ready pulse |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry bit |
| pc_o | output | 12 | Program counter |
| run_o | output | 1 | Run flag |
| ien_o | output | 1 | Interrupt enable |
| fgi_o | output | 1 | Input flag |
| fgo_o | output | 1 | Output flag |
| out_data_o | output | 8 | Output register |
| sc_clr_o | output | 1 | Step counter clear request |

## Verification
The assertions check the following on every cycle: state holds while no instruction executes, the right rotate moves bits through the carry, the zero skip advances the counter, halt drops the run flag and it never comes back, a strobe raises the input flag, interrupt-on takes effect, and a malformed register-group field is a no-op. Other behaviours only the bench's scenarios can show. These are the arithmetic wrap of increment, the collision of a strobe with a same-cycle flag clear, the byte transfers through the input and output registers, and the program counter wrapping after a long run of skips.

// File: rtl/regio_pkg.sv
// Shared definitions for the register and I/O instruction unit.
// Assumes a fixed 12-bit operation field and a 6-bit I/O select window.
package regio_pkg;
    localparam int unsigned OP_W    = 12;
    localparam int unsigned IO_SEL  = 6;

    // One flag per decoded operation; at most one is set in any cycle.
    typedef struct packed {
        logic cla, cle, cma, cme, cir, cil, inc;
        logic spa, sna, sza, sze, hlt;
        logic inp, outp, ski, sko, ion, iof;
    } regio_op_t;
endpackage

// File: rtl/regio_decode.sv
// Turns the execute strobe, the group bit and the one-hot field into
// individual operation flags. Assumes the caller raises exec only in
// the execute step; a field not exactly one-hot in its window yields no flag.
module regio_decode
    import regio_pkg::*;
(
    input  logic            exec,
    input  logic            mode,
    input  logic [OP_W-1:0] bits,
    output regio_op_t       op
);
    logic [OP_W-1:0]   reg_v;
    logic [IO_SEL-1:0] io_v;

    // Qualify each group's select window by strobe, group and one-hotness.
    always_comb begin
        reg_v = (exec && !mode && $onehot(bits)) ? bits : '0;
        io_v  = (exec && mode && $onehot(bits[OP_W-1 -: IO_SEL]))
                ? bits[OP_W-1 -: IO_SEL] : '0;
    end

    // Map field positions onto named operation flags.
    always_comb begin
        op      = '0;
        op.cla  = reg_v[11];
        op.cle  = reg_v[10];
        op.cma  = reg_v[9];
        op.cme  = reg_v[8];
        op.cir  = reg_v[7];
        op.cil  = reg_v[6];
        op.inc  = reg_v[5];
        op.spa  = reg_v[4];
        op.sna  = reg_v[3];
        op.sza  = reg_v[2];
        op.sze  = reg_v[1];
        op.hlt  = reg_v[0];
        op.inp  = io_v[5];
        op.outp = io_v[4];
        op.ski  = io_v[3];
        op.sko  = io_v[2];
        op.ion  = io_v[1];
        op.iof  = io_v[0];
    end
endmodule

// File: rtl/regio_acc_alu.sv
// Next-value logic for the accumulator and carry, plus the skip
// conditions that depend on them. Assumes at most one op flag is set.
module regio_acc_alu
    import regio_pkg::*;
#(
    parameter int unsigned AC_W = 16,
    parameter int unsigned IO_W = 8
) (
    input  regio_op_t       op,
    input  logic [AC_W-1:0] ac,
    input  logic            e,
    input  logic [IO_W-1:0] inpr,
    output logic [AC_W-1:0] ac_nxt,
    output logic            e_nxt,
    output logic            acc_skip
);
    localparam int unsigned MSB = AC_W - 1;

    // Select the new accumulator and carry for the active operation.
    always_comb begin
        ac_nxt = ac;
        e_nxt  = e;
        if (op.cla) ac_nxt = '0;
        if (op.cle) e_nxt = 1'b0;
        if (op.cma) ac_nxt = ~ac;
        if (op.cme) e_nxt = ~e;
        if (op.cir) begin
            ac_nxt = {e, ac[MSB:1]};
            e_nxt  = ac[0];
        end
        if (op.cil) begin
            ac_nxt = {ac[MSB-1:0], e};
            e_nxt  = ac[MSB];
        end
        if (op.inc) ac_nxt = ac + 1'b1;
        if (op.inp) ac_nxt[IO_W-1:0] = inpr;
    end

    // Evaluate the accumulator and carry skip conditions.
    always_comb begin
        acc_skip = (op.spa && !ac[MSB]) || (op.sna && ac[MSB]) ||
                   (op.sza && (ac == '0)) || (op.sze && !e);
    end
endmodule

// File: rtl/regio_flags.sv
// Holds the input register, the input and output ready flags and the
// interrupt enable. Assumes device pulses are one cycle wide; a device
// pulse wins over a same-cycle clear by an instruction.
module regio_flags
    import regio_pkg::*;
#(
    parameter int unsigned IO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  regio_op_t       op,
    input  logic [IO_W-1:0] in_data,
    input  logic            in_strobe,
    input  logic            out_ready,
    output logic [IO_W-1:0] inpr,
    output logic            fgi,
    output logic            fgo,
    output logic            ien,
    output logic            io_skip
);
    // Update the input register, both ready flags and the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inpr <= '0;
            fgi  <= 1'b0;
            fgo  <= 1'b0;
            ien  <= 1'b0;
        end else begin
            if (in_strobe) inpr <= in_data;
            if (in_strobe)      fgi <= 1'b1;
            else if (op.inp)    fgi <= 1'b0;
            if (out_ready)      fgo <= 1'b1;
            else if (op.outp)   fgo <= 1'b0;
            if (op.ion)         ien <= 1'b1;
            else if (op.iof)    ien <= 1'b0;
        end
    end

    // Flag-based skip conditions.
    always_comb io_skip = (op.ski && fgi) || (op.sko && fgo);
endmodule

// File: rtl/regio_exec_unit.sv
// Execute stage for non-memory instructions. Holds accumulator, carry,
// program counter, run flag and output register; asks the sequencer to
// restart whenever exec_t3 is high. Assumes IO_W <= AC_W.
module regio_exec_unit
    import regio_pkg::*;
#(
    parameter int unsigned AC_W = 16,
    parameter int unsigned PC_W = 12,
    parameter int unsigned IO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_t3,
    input  logic            mode_i,
    input  logic [OP_W-1:0] op_bits,
    input  logic [IO_W-1:0] in_data,
    input  logic            in_strobe,
    input  logic            out_ready,
    output logic [AC_W-1:0] ac_o,
    output logic            e_o,
    output logic [PC_W-1:0] pc_o,
    output logic            run_o,
    output logic            ien_o,
    output logic            fgi_o,
    output logic            fgo_o,
    output logic [IO_W-1:0] out_data_o,
    output logic            sc_clr_o
);
    regio_op_t       op;
    logic [AC_W-1:0] ac_q, ac_nxt;
    logic            e_q, e_nxt;
    logic [PC_W-1:0] pc_q;
    logic            run_q;
    logic [IO_W-1:0] outr_q, inpr;
    logic            acc_skip, io_skip;

    regio_decode u_dec (
        .exec (exec_t3),
        .mode (mode_i),
        .bits (op_bits),
        .op   (op)
    );

    regio_acc_alu #(.AC_W(AC_W), .IO_W(IO_W)) u_alu (
        .op       (op),
        .ac       (ac_q),
        .e        (e_q),
        .inpr     (inpr),
        .ac_nxt   (ac_nxt),
        .e_nxt    (e_nxt),
        .acc_skip (acc_skip)
    );

    regio_flags #(.IO_W(IO_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .in_data   (in_data),
        .in_strobe (in_strobe),
        .out_ready (out_ready),
        .inpr      (inpr),
        .fgi       (fgi_o),
        .fgo       (fgo_o),
        .ien       (ien_o),
        .io_skip   (io_skip)
    );

    // Commit accumulator, carry, program counter, run flag and output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q   <= '0;
            e_q    <= 1'b0;
            pc_q   <= '0;
            run_q  <= 1'b1;
            outr_q <= '0;
        end else begin
            ac_q <= ac_nxt;
            e_q  <= e_nxt;
            if (acc_skip || io_skip) pc_q <= pc_q + 1'b1;
            if (op.hlt)  run_q  <= 1'b0;
            if (op.outp) outr_q <= ac_q[IO_W-1:0];
        end
    end

    // Drive the outputs from the held state.
    always_comb begin
        ac_o       = ac_q;
        e_o        = e_q;
        pc_o       = pc_q;
        run_o      = run_q;
        out_data_o = outr_q;
        sc_clr_o   = exec_t3;
    end
endmodule

// File: rtl/regio_exec_chk.sv
// Cycle-level properties of the register and I/O instruction unit,
// observed only at its ports and attached by bind.
module regio_exec_chk #(
    parameter int unsigned AC_W = 16,
    parameter int unsigned PC_W = 12,
    parameter int unsigned IO_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec_t3,
    input logic            mode_i,
    input logic [11:0]     op_bits,
    input logic            in_strobe,
    input logic [AC_W-1:0] ac_o,
    input logic            e_o,
    input logic [PC_W-1:0] pc_o,
    input logic            run_o,
    input logic            ien_o,
    input logic            fgi_o,
    input logic [IO_W-1:0] out_data_o
);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_t3 |=> $stable(ac_o) && $stable(e_o) && $stable(pc_o) &&
                     $stable(run_o) && $stable(ien_o) && $stable(out_data_o));

    // R5
    rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_t3 && !mode_i && op_bits == 12'h080) |=>
            (ac_o == {$past(e_o), $past(ac_o[AC_W-1:1])}) && (e_o == $past(ac_o[0])));

    // R7
    zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_t3 && !mode_i && op_bits == 12'h004 && ac_o == '0) |=>
            pc_o == $past(pc_o) + 1'b1);

    // R8
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_t3 && !mode_i && op_bits == 12'h001) |=> !run_o);

    // R8
    run_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(run_o));

    // R9
    fgi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |=> fgi_o);

    // R12
    ien_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_t3 && mode_i && op_bits[11:6] == 6'b000010) |=> ien_o);

    // R13
    bad_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_t3 && !mode_i && !$onehot(op_bits)) |=>
            $stable(ac_o) && $stable(e_o) && $stable(pc_o) && $stable(run_o));
endmodule

bind regio_exec_unit regio_exec_chk #(.AC_W(AC_W), .PC_W(PC_W), .IO_W(IO_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_t3    (exec_t3),
    .mode_i     (mode_i),
    .op_bits    (op_bits),
    .in_strobe  (in_strobe),
    .ac_o       (ac_o),
    .e_o        (e_o),
    .pc_o       (pc_o),
    .run_o      (run_o),
    .ien_o      (ien_o),
    .fgi_o      (fgi_o),
    .out_data_o (out_data_o)
);

// File: tb/test_regio_exec_unit.sv
`timescale 1ns/1ps
module test_regio_exec_unit;
    typedef struct packed {
        logic [15:0] ac;
        logic        e;
        logic [11:0] pc;
        logic        run;
        logic        ien;
        logic        fgi;
        logic        fgo;
        logic [7:0]  outd;
    } snap_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_t3 = 1'b0;
    logic        mode_i = 1'b0;
    logic [11:0] op_bits = '0;
    logic [7:0]  in_data = '0;
    logic        in_strobe = 1'b0;
    logic        out_ready = 1'b0;
    logic [15:0] ac_o;
    logic        e_o;
    logic [11:0] pc_o;
    logic        run_o, ien_o, fgi_o, fgo_o, sc_clr_o;
    logic [7:0]  out_data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    snap_t m;
    logic [7:0] m_inpr;
    snap_t exp_q[$];
    int    due_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    regio_exec_unit i_regio_exec_unit (
        .clk(clk), .rst_n(rst_n), .exec_t3(exec_t3), .mode_i(mode_i),
        .op_bits(op_bits), .in_data(in_data), .in_strobe(in_strobe),
        .out_ready(out_ready), .ac_o(ac_o), .e_o(e_o), .pc_o(pc_o),
        .run_o(run_o), .ien_o(ien_o), .fgi_o(fgi_o), .fgo_o(fgo_o),
        .out_data_o(out_data_o), .sc_clr_o(sc_clr_o)
    );

    function automatic snap_t actual();
        return '{ac_o, e_o, pc_o, run_o, ien_o, fgi_o, fgo_o, out_data_o};
    endfunction

    task automatic check(input snap_t got, input snap_t exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Driver: one cycle of stimulus, model update, push expected.
    task automatic step(input logic ex, input logic md, input logic [11:0] b,
                        input logic stb, input logic [7:0] d, input logic rdy,
                        input string tag);
        snap_t o;
        logic v;
        @(negedge clk);
        exec_t3 = ex; mode_i = md; op_bits = b;
        in_strobe = stb; in_data = d; out_ready = rdy;
        #1;
        checks++;
        if (sc_clr_o !== ex) begin
            errors++;
            $display("FAIL R2: actual=%b expected=%b", sc_clr_o, ex);
        end
        o = m;
        v = ex && (md ? $onehot(b[11:6]) : $onehot(b));
        if (v && !md) begin
            if (b[11]) m.ac = '0;
            if (b[10]) m.e = 1'b0;
            if (b[9])  m.ac = ~o.ac;
            if (b[8])  m.e = ~o.e;
            if (b[7])  begin m.ac = {o.e, o.ac[15:1]}; m.e = o.ac[0]; end
            if (b[6])  begin m.ac = {o.ac[14:0], o.e}; m.e = o.ac[15]; end
            if (b[5])  m.ac = o.ac + 16'd1;
            if ((b[4] && !o.ac[15]) || (b[3] && o.ac[15]) ||
                (b[2] && o.ac == 0) || (b[1] && !o.e)) m.pc = o.pc + 12'd1;
            if (b[0])  m.run = 1'b0;
        end
        if (v && md) begin
            if (b[11]) begin m.ac[7:0] = m_inpr; m.fgi = 1'b0; end
            if (b[10]) begin m.outd = o.ac[7:0]; m.fgo = 1'b0; end
            if ((b[9] && o.fgi) || (b[8] && o.fgo)) m.pc = o.pc + 12'd1;
            if (b[7])  m.ien = 1'b1;
            if (b[6])  m.ien = 1'b0;
        end
        if (stb) begin m.fgi = 1'b1; m_inpr = d; end
        if (rdy) m.fgo = 1'b1;
        exp_q.push_back(m);
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 12'h000, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic rop(input logic [11:0] b, input string tag);
        step(1'b1, 1'b0, b, 1'b0, 8'h00, 1'b0, tag);
    endtask

    task automatic iop(input logic [11:0] b, input string tag);
        step(1'b1, 1'b1, b, 1'b0, 8'h00, 1'b0, tag);
    endtask

    // Monitor: pop expected items when due and compare with the ports.
    initial begin
        forever begin
            @(negedge clk);
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                check(actual(), exp_q[0], tag_q[0]);
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        m = '{16'h0000, 1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00};
        m_inpr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(actual(), m, "R1 reset");

        rop(12'h800, "R4 clear ac");
        rop(12'h200, "R4 complement ac");
        rop(12'h020, "R6 increment wraps");
        rop(12'h100, "R4 complement e");
        rop(12'h080, "R5 rotate right");
        rop(12'h040, "R5 rotate left");
        rop(12'h040, "R5 rotate left again");
        rop(12'h020, "R6 increment");
        rop(12'h010, "R7 skip positive");
        rop(12'h008, "R7 skip negative no");
        rop(12'h004, "R7 skip zero no");
        rop(12'h002, "R7 skip e zero");
        rop(12'h100, "R4 complement e set");
        rop(12'h400, "R4 clear e");
        rop(12'h200, "R4 complement nonzero");
        rop(12'h008, "R7 skip negative");
        rop(12'h003, "R13 two bits");
        rop(12'h000, "R13 no bits");
        idle("R3 idle");
        step(1'b0, 1'b0, 12'h800, 1'b0, 8'h00, 1'b0, "R3 field without exec");
        for (int i = 0; i < 4096; i++) rop(12'h002, "R7 pc wrap");

        step(1'b0, 1'b0, 12'h000, 1'b1, 8'hA5, 1'b0, "R9 strobe");
        iop(12'h200, "R11 skip input flag");
        iop(12'h800, "R9 input byte");
        iop(12'h200, "R11 no skip input");
        iop(12'h100, "R11 no skip output");
        step(1'b1, 1'b1, 12'h800, 1'b1, 8'h3C, 1'b0, "R9 strobe beats clear");
        iop(12'h800, "R9 input again");
        step(1'b0, 1'b0, 12'h000, 1'b0, 8'h00, 1'b1, "R10 ready");
        iop(12'h100, "R11 skip output flag");
        iop(12'h400, "R10 output byte");
        step(1'b1, 1'b1, 12'h400, 1'b0, 8'h00, 1'b1, "R10 ready beats clear");
        iop(12'h080, "R12 interrupt on");
        iop(12'h0BF, "R13 low bits ignored");
        iop(12'h040, "R12 interrupt off");
        iop(12'h0C0, "R13 io two bits");
        iop(12'h03F, "R13 io no window bit");
        rop(12'h001, "R8 halt");
        idle("R8 stays halted");
        idle("R3 idle end");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule